// File: doc/BRIEF.md
# Burst Read/Write Memory Arbiter

This block shares one single-ported external pixel memory between a video capture stream and a display refresh stream. Capture pixels wait in a write FIFO and display pixels are delivered into a read FIFO. The block drains one FIFO and fills the other in fixed-length bursts of sequential addresses, so the slow row-open latency of the memory is paid once per burst instead of once per pixel. Because both sides are buffered on chip, the capture clock domain and the display refresh never need to line up.

Each burst is chosen from the FIFO fill levels and the display blanking flag at the moment the arbiter is idle. A write burst needs a full burst of pixels waiting. A read burst needs room for a full burst. When both are possible, the read side wins if its FIFO is nearly empty or the display is blanking. Otherwise the direction alternates. Once the memory grants a burst, it runs to its last word. Each stream keeps its own frame address, which wraps at the image size and restarts on that stream's frame marker. Pixels are 16-bit RGB565 words, one pixel per memory word, and default to a 256x384 image.

Top module: `burst_mem_arbiter`

## Requirements
- R1: A write burst is requested only when the write FIFO level is at least BURST words.
- R2: A read burst is requested only when the read FIFO level is at most FIFO_DEPTH minus BURST.
- R3: A granted burst transfers exactly BURST words (memLen reads BURST), one per cycle in which memWrReady (write) or memRdValid (read) is high, and it cannot be interrupted; stall cycles lengthen it.
- R4: Once memReq is raised, it stays high with memWrite and memAddr unchanged until the cycle that memGrant is seen.
- R5: When both directions are eligible and the read FIFO level is below LOW_WM, the read burst is chosen.
- R6: When both directions are eligible, the read level is not below LOW_WM, and dispBlank is high, the read burst is chosen.
- R7: When both directions are eligible in any other case, the direction is the opposite of the previous burst; after reset, the previous burst counts as a read.
- R8: Each stream's address starts at 0, advances by BURST after each of its bursts, and returns to 0 after the last burst of the frame (IMG_W*IMG_H words).
- R9: A frame marker (capFrameStart for writes, dispFrameStart for reads) seen while its stream has no burst requested or running makes that stream's next burst start at 0. If it is seen during such a burst, that burst completes at its own address and the following one starts at 0.
- R10: Write beats pop the write FIFO head once per accepted word and present it unchanged on memWrData. Read beats push memRdData unchanged into the read FIFO, in order. A 16-bit RGB565 pixel is one word.
- R11: memRdValid and memWrReady have no effect (no push, no pop) outside a burst of the matching direction.
- R12: After reset there is no request, pop or push, and both stream addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capFrameStart | input | 1 | Capture frame marker, restarts write addressing |
| dispFrameStart | input | 1 | Display frame marker, restarts read addressing |
| dispBlank | input | 1 | Display is in a blanking interval |
| wrLevel | input | LVL_W | Words waiting in the write FIFO |
| wrData | input | PIX_W | Write FIFO head word (show-ahead) |
| wrPop | output | 1 | Pops the write FIFO head |
| rdLevel | input | LVL_W | Words held in the read FIFO |
| rdPush | output | 1 | Pushes rdData into the read FIFO |
| rdData | output | PIX_W | Pixel for the read FIFO |
| memReq | output | 1 | Burst request to memory |
| memWrite | output | 1 | Burst direction, 1 = write |
| memAddr | output | ADDR_W | First word address of the burst |
| memLen | output | LEN_W | Burst length in words |
| memGrant | input | 1 | Memory accepts the pending request |
| memWrData | output | PIX_W | Write word for the current beat |
| memWrReady | input | 1 | Memory takes memWrData this cycle |
| memRdData | input | PIX_W | Read word from memory |
| memRdValid | input | 1 | memRdData is valid this cycle |

## Verification
The bench targets the tie-break cases: read urgency against alternation, and blanking against alternation. A design that ignored either one would issue a write first and leave the display FIFO short. It checks the frame wrap and both cases of the frame markers. A design that applied a marker in the middle of a burst would move the address of a burst that was already granted, and one that dropped the pending marker would continue the old frame. Memory stall cycles and grant latency show whether a design counts clock cycles instead of accepted words, or changes its request while waiting. Stray valid and ready pulses while idle show whether a design pushes or pops outside a burst.

// File: rtl/burst_arb_pkg.sv
package burst_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrSel;  // write burst requested or running
    logic rdSel;  // read burst requested or running
    logic take;   // grant accepted this cycle
    logic beat;   // one word moves this cycle
    logic done;   // last word of the burst moves this cycle
  } arbStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import burst_arb_pkg::*;
#(
  parameter int BURST      = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int LOW_WM     = 16,
  parameter int LVL_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] wrLevel,
  input  logic [LVL_W-1:0] rdLevel,
  input  logic             dispBlank,
  input  logic             memGrant,
  input  logic             memWrReady,
  input  logic             memRdValid,
  input  logic             lastBeat,
  output arbStrobe_t       strobe,
  output logic             memReq,
  output logic             memWrite
);

  localparam logic [LVL_W:0] BURST_L  = (LVL_W+1)'(BURST);
  localparam logic [LVL_W:0] RD_LIMIT = (LVL_W+1)'(FIFO_DEPTH - BURST);
  localparam logic [LVL_W:0] WM_L     = (LVL_W+1)'(LOW_WM);

  arbState_t stateQ;
  logic      dirWrQ;
  logic      lastWasWrQ;

  logic wrOk, rdOk, rdUrgent, anyOk, pickWr, beat;

  always_comb begin
    wrOk     = {1'b0, wrLevel} >= BURST_L;
    rdOk     = {1'b0, rdLevel} <= RD_LIMIT;
    rdUrgent = {1'b0, rdLevel} <  WM_L;
    anyOk    = wrOk | rdOk;
    if (wrOk && rdOk) begin
      if (rdUrgent || dispBlank) pickWr = 1'b0;
      else                       pickWr = !lastWasWrQ;
    end else begin
      pickWr = wrOk;
    end
  end

  assign beat = (stateQ == ST_XFER) && (dirWrQ ? memWrReady : memRdValid);

  always_comb begin
    strobe.wrSel = (stateQ != ST_IDLE) &&  dirWrQ;
    strobe.rdSel = (stateQ != ST_IDLE) && !dirWrQ;
    strobe.take  = (stateQ == ST_REQ) && memGrant;
    strobe.beat  = beat;
    strobe.done  = beat && lastBeat;
  end

  assign memReq   = (stateQ == ST_REQ);
  assign memWrite = dirWrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      dirWrQ     <= 1'b0;
      lastWasWrQ <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (anyOk) begin
          stateQ <= ST_REQ;
          dirWrQ <= pickWr;
        end
        ST_REQ: if (memGrant) stateQ <= ST_XFER;
        ST_XFER: if (beat && lastBeat) begin
          stateQ     <= ST_IDLE;
          lastWasWrQ <= dirWrQ;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R1: a write request follows a write FIFO holding a full burst
  a_r1_wr_full_burst: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && memWrite |-> $past({1'b0, wrLevel}) >= BURST_L);

  // R2: a read request follows a read FIFO with room for a full burst
  a_r2_rd_room: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && !memWrite |-> $past({1'b0, rdLevel}) <= RD_LIMIT);

  // R5: a starving display wins the tie
  a_r5_urgent_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && $past(wrOk && rdOk && rdUrgent) |-> !memWrite);

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import burst_arb_pkg::*;
#(
  parameter int BURST       = 16,
  parameter int FRAME_WORDS = 98304,
  parameter int ADDR_W      = 17,
  parameter int CNT_W       = 4,
  parameter int PIX_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic              capFrameStart,
  input  logic              dispFrameStart,
  input  logic [PIX_W-1:0]  wrData,
  input  logic [PIX_W-1:0]  memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PIX_W-1:0]  memWrData,
  output logic              wrPop,
  output logic              rdPush,
  output logic [PIX_W-1:0]  rdData,
  output logic              lastBeat
);

  localparam logic [ADDR_W:0]  STEP  = (ADDR_W+1)'(BURST);
  localparam logic [ADDR_W:0]  FRAME = (ADDR_W+1)'(FRAME_WORDS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(BURST - 1);

  logic [1:0] mark, active;
  assign mark   = {dispFrameStart, capFrameStart};
  assign active = {strobe.rdSel, strobe.wrSel};

  // stream 0 = write (capture), stream 1 = read (display)
  for (genvar g = 0; g < 2; g++) begin : gStream
    logic [ADDR_W-1:0] addrQ;
    logic              pendQ;
    logic [ADDR_W:0]   bumped;

    assign bumped = {1'b0, addrQ} + STEP;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ <= '0;
        pendQ <= 1'b0;
      end else if (strobe.done && active[g]) begin
        addrQ <= (pendQ || mark[g] || bumped >= FRAME) ? '0 : bumped[ADDR_W-1:0];
        pendQ <= 1'b0;
      end else if (mark[g]) begin
        if (active[g]) pendQ <= 1'b1;
        else           addrQ <= '0;
      end
    end

    // R9: a marker outside a burst of this stream restarts it at zero
    a_r9_marker_restart: assert property (@(posedge clk) disable iff (!rstN)
      mark[g] && !active[g] |=> addrQ == '0);
  end

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN)            cntQ <= '0;
    else if (strobe.take) cntQ <= '0;
    else if (strobe.beat) cntQ <= cntQ + 1'b1;
  end

  assign lastBeat  = (cntQ == LAST);
  assign memAddr   = strobe.rdSel ? gStream[1].addrQ : gStream[0].addrQ;
  assign memWrData = wrData;
  assign wrPop     = strobe.beat && strobe.wrSel;
  assign rdPush    = strobe.beat && strobe.rdSel;
  assign rdData    = memRdData;

  // R8: burst addresses stay inside the frame and on burst boundaries
  a_r8_addr_legal: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrSel || strobe.rdSel) |->
      ({1'b0, memAddr} < FRAME) && ({1'b0, memAddr} % STEP == '0));

endmodule

// File: rtl/burst_mem_arbiter.sv
module burst_mem_arbiter
  import burst_arb_pkg::*;
#(
  parameter int IMG_W      = 256,
  parameter int IMG_H      = 384,
  parameter int PIX_W      = 16,
  parameter int BURST      = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int LOW_WM     = 16,
  localparam int FRAME_WORDS = IMG_W * IMG_H,
  localparam int ADDR_W      = $clog2(FRAME_WORDS),
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1),
  localparam int LEN_W       = $clog2(BURST + 1),
  localparam int CNT_W       = $clog2(BURST)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capFrameStart,
  input  logic              dispFrameStart,
  input  logic              dispBlank,
  input  logic [LVL_W-1:0]  wrLevel,
  input  logic [PIX_W-1:0]  wrData,
  output logic              wrPop,
  input  logic [LVL_W-1:0]  rdLevel,
  output logic              rdPush,
  output logic [PIX_W-1:0]  rdData,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  input  logic              memGrant,
  output logic [PIX_W-1:0]  memWrData,
  input  logic              memWrReady,
  input  logic [PIX_W-1:0]  memRdData,
  input  logic              memRdValid
);

  arbStrobe_t strobe;
  logic       lastBeat;

  arb_ctrl #(
    .BURST(BURST), .FIFO_DEPTH(FIFO_DEPTH), .LOW_WM(LOW_WM), .LVL_W(LVL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrLevel(wrLevel), .rdLevel(rdLevel),
    .dispBlank(dispBlank), .memGrant(memGrant), .memWrReady(memWrReady),
    .memRdValid(memRdValid), .lastBeat(lastBeat), .strobe(strobe),
    .memReq(memReq), .memWrite(memWrite)
  );

  arb_datapath #(
    .BURST(BURST), .FRAME_WORDS(FRAME_WORDS), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .PIX_W(PIX_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capFrameStart(capFrameStart),
    .dispFrameStart(dispFrameStart), .wrData(wrData), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .wrPop(wrPop), .rdPush(rdPush),
    .rdData(rdData), .lastBeat(lastBeat)
  );

  assign memLen = LEN_W'(BURST);

  // R4: a pending request keeps its direction and address
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGrant |=> memReq && $stable(memWrite) && $stable(memAddr));

  // R10: one FIFO moves per cycle at most
  a_r10_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPop && rdPush));

  // R11: no FIFO movement without a memory request having been granted
  a_r11_no_idle_move: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !wrPop && !rdPush);

endmodule

// File: tb/tb_burst_mem_arbiter.sv
module tb_burst_mem_arbiter;

  localparam int IMG_W = 8, IMG_H = 4, PIX_W = 16, BURST = 4;
  localparam int DEPTH = 16, LOW_WM = 4;
  localparam int FRAME = IMG_W * IMG_H;
  localparam int ADDR_W = $clog2(FRAME);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int LEN_W = $clog2(BURST + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capFrameStart = 1'b0, dispFrameStart = 1'b0, dispBlank = 1'b0;
  logic [LVL_W-1:0] wrLevel, rdLvl;
  logic [PIX_W-1:0] wrData, rdData, memWrData;
  logic [PIX_W-1:0] memRdData = '0;
  logic wrPop, rdPush, memReq, memWrite;
  logic memGrant = 1'b0, memWrReady = 1'b0, memRdValid = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [LEN_W-1:0] memLen;

  always #5 clk = ~clk;

  burst_mem_arbiter #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .BURST(BURST),
    .FIFO_DEPTH(DEPTH), .LOW_WM(LOW_WM)
  ) dut (
    .clk(clk), .rstN(rstN), .capFrameStart(capFrameStart),
    .dispFrameStart(dispFrameStart), .dispBlank(dispBlank),
    .wrLevel(wrLevel), .wrData(wrData), .wrPop(wrPop), .rdLevel(rdLvl),
    .rdPush(rdPush), .rdData(rdData), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memLen(memLen), .memGrant(memGrant),
    .memWrData(memWrData), .memWrReady(memWrReady), .memRdData(memRdData),
    .memRdValid(memRdValid)
  );

  // write FIFO model (show-ahead)
  logic [PIX_W-1:0] wrBuf [0:255];
  int wrHead = 0, wrTail = 0;
  assign wrLevel = LVL_W'(wrTail - wrHead);
  assign wrData  = wrBuf[wrHead[7:0]];

  // memory model, burst log, received read words
  logic [PIX_W-1:0] mem [0:FRAME-1];
  logic [PIX_W-1:0] rxBuf [0:255];
  int rxCnt = 0;
  int logDir [0:63];
  int logAddr [0:63];
  int logCnt = 0;
  int mPhase = 0, mLat = 0, mK = 0, mBase = 0, mDir = 0;
  bit mStall = 0, spurious = 0;

  int nTests = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    memGrant   = 1'b0;
    memWrReady = 1'b0;
    memRdValid = 1'b0;
    case (mPhase)
      0: begin
        if (memReq) begin
          mPhase = 1; mLat = 0; mDir = int'(memWrite); mBase = int'(memAddr);
        end else if (spurious) begin
          memWrReady = 1'b1; memRdValid = 1'b1; memRdData = 16'hDEAD;
        end
      end
      1: begin
        // R4: request held unchanged while waiting
        check(memReq && int'(memWrite) == mDir && int'(memAddr) == mBase,
              "R4 request hold", int'(memAddr), mBase);
        mLat++;
        if (mLat == 3) begin
          memGrant = 1'b1;
          check(int'(memLen) == BURST, "R3 burst length", int'(memLen), BURST);
          logDir[logCnt] = mDir; logAddr[logCnt] = mBase; logCnt++;
          mPhase = 2; mK = 0; mStall = 0;
        end
      end
      default: begin
        if (mK == 1 && !mStall) begin
          mStall = 1;
        end else if (mK < BURST) begin
          if (mDir == 1) begin
            mem[mBase + mK] = memWrData; memWrReady = 1'b1;
          end else begin
            memRdData = mem[mBase + mK]; memRdValid = 1'b1;
          end
          mK++;
        end else begin
          mPhase = 0;
        end
      end
    endcase
    #2;
    if (wrPop) wrHead++;
    if (rdPush) begin rxBuf[rxCnt[7:0]] = rdData; rxCnt++; end
  end

  task automatic push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wrBuf[wrTail[7:0]] = PIX_W'(base + i);
      wrTail++;
    end
  endtask

  task automatic waitLog(input int n);
    for (int i = 0; i < 300 && logCnt < n; i++) @(negedge clk);
    check(logCnt >= n, "burst expected", logCnt, n);
  endtask

  task automatic waitQuiet();
    int q = 0;
    for (int i = 0; i < 400 && q < 4; i++) begin
      @(negedge clk);
      if (mPhase == 0 && !memReq) q++; else q = 0;
    end
  endtask

  task automatic expBurst(input int idx, input int dir, input int addr, input string req);
    check(logDir[idx] == dir, req, logDir[idx], dir);
    check(logAddr[idx] == addr, req, logAddr[idx], addr);
  endtask

  task automatic singleRead();
    int s = logCnt;
    rdLvl = LVL_W'(DEPTH - BURST);
    waitLog(s + 1);
    rdLvl = LVL_W'(DEPTH);
    waitQuiet();
  endtask

  task automatic tReset();
    check(!memReq && !wrPop && !rdPush, "R12 idle after reset", int'(memReq), 0);
    check(memAddr == '0, "R12 address zero", int'(memAddr), 0);
  endtask

  task automatic tWriteThreshold();
    int s = logCnt;
    push(BURST - 1, 16'hF800);
    repeat (20) @(negedge clk);
    check(logCnt == s, "R1 no write below a burst", logCnt, s);
    push(1, 16'hF800 + BURST - 1);
    waitLog(s + 1); waitQuiet();
    expBurst(s, 1, 0, "R1 write burst at 0");
    for (int i = 0; i < BURST; i++)
      check(mem[i] == PIX_W'(16'hF800 + i), "R10 write data", int'(mem[i]), 16'hF800 + i);
    check(wrHead == wrTail, "R3 one pop per word", wrHead, wrTail);
  endtask

  task automatic tReadRoom();
    int s = logCnt, r = rxCnt;
    rdLvl = LVL_W'(DEPTH - BURST + 1);
    repeat (20) @(negedge clk);
    check(logCnt == s, "R2 no read without room", logCnt, s);
    singleRead();
    expBurst(s, 0, 0, "R2 read burst at 0");
    check(rxCnt == r + BURST, "R3 read word count", rxCnt - r, BURST);
    for (int i = 0; i < BURST; i++)
      check(rxBuf[r + i] == mem[i], "R10 read data", int'(rxBuf[r + i]), int'(mem[i]));
  endtask

  task automatic tAlternate();
    int s = logCnt, r = rxCnt;
    push(3 * BURST, 16'h07E0);
    rdLvl = 8;
    waitLog(s + 5);
    rdLvl = LVL_W'(DEPTH);
    waitQuiet();
    expBurst(s, 1, 4, "R7 alternation");
    expBurst(s + 1, 0, 4, "R7 alternation");
    expBurst(s + 2, 1, 8, "R7 alternation");
    expBurst(s + 3, 0, 8, "R7 alternation");
    expBurst(s + 4, 1, 12, "R8 write advance");
    check(rxBuf[r + 4] == PIX_W'(16'h07E0 + 4), "R10 read after write",
          int'(rxBuf[r + 4]), 16'h07E0 + 4);
  endtask

  task automatic tUrgent();
    int s;
    singleRead();
    s = logCnt;
    push(BURST, 16'h001F);
    rdLvl = 2;
    waitLog(s + 1);
    rdLvl = LVL_W'(DEPTH);
    waitQuiet();
    expBurst(s, 0, 16, "R5 urgent read wins");
    expBurst(s + 1, 1, 16, "R5 write follows");
  endtask

  task automatic tBlank();
    int s;
    singleRead();
    s = logCnt;
    dispBlank = 1'b1;
    push(BURST, 16'h1234);
    rdLvl = 8;
    waitLog(s + 1);
    rdLvl = LVL_W'(DEPTH);
    waitQuiet();
    dispBlank = 1'b0;
    expBurst(s, 0, 24, "R6 blanking read wins");
    expBurst(s + 1, 1, 20, "R6 write follows");
  endtask

  task automatic tWrap();
    int s = logCnt;
    push(3 * BURST, 16'hA500);
    waitLog(s + 3); waitQuiet();
    expBurst(s, 1, 24, "R8 advance");
    expBurst(s + 1, 1, 28, "R8 last burst of frame");
    expBurst(s + 2, 1, 0, "R8 wrap to zero");
    check(mem[0] == PIX_W'(16'hA500 + 2 * BURST), "R8 wrapped data",
          int'(mem[0]), 16'hA500 + 2 * BURST);
  endtask

  task automatic tMarkers();
    int s = logCnt;
    capFrameStart = 1'b1; @(negedge clk); capFrameStart = 1'b0;
    push(BURST, 16'h5A00);
    waitLog(s + 1); waitQuiet();
    expBurst(s, 1, 0, "R9 idle marker");
    push(BURST, 16'h5B00);
    waitLog(s + 2);
    for (int i = 0; i < 20 && mPhase != 2; i++) @(negedge clk);
    capFrameStart = 1'b1; @(negedge clk); capFrameStart = 1'b0;
    waitQuiet();
    expBurst(s + 1, 1, 4, "R9 marker keeps running burst");
    push(BURST, 16'h5C00);
    waitLog(s + 3); waitQuiet();
    expBurst(s + 2, 1, 0, "R9 pending marker restart");
    dispFrameStart = 1'b1; @(negedge clk); dispFrameStart = 1'b0;
    singleRead();
    expBurst(s + 3, 0, 0, "R9 display marker");
  endtask

  task automatic tSpurious();
    int r = rxCnt, h = wrHead, s = logCnt;
    push(2, 16'h3333);
    spurious = 1;
    repeat (8) @(negedge clk);
    spurious = 0;
    repeat (2) @(negedge clk);
    check(rxCnt == r, "R11 no push when idle", rxCnt, r);
    check(wrHead == h, "R11 no pop when idle", wrHead, h);
    check(logCnt == s, "R11 no burst", logCnt, s);
  endtask

  initial begin
    rdLvl = LVL_W'(DEPTH);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWriteThreshold();
    tReadRoom();
    tAlternate();
    tUrgent();
    tBlank();
    tWrap();
    tMarkers();
    tSpurious();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", logCnt, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule